// File: doc/BRIEF.md
# Floating-Point Significand Rounding Unit

This block is the final rounding stage of a double-precision floating-point datapath. An earlier normalize or denormalize step delivers a sign, a biased 11-bit exponent, a 53-bit significand that includes the explicit leading bit, and three bits that lie beyond it: guard, round and sticky. A 2-bit mode select chooses the rounding direction. The block forms the two representable neighbours of the exact value, one above it and one below it in the signed sense, and picks one of them. It returns the rounded sign, exponent and significand, and an inexact flag.

The logic is purely combinational. It has no clock, no reset and no state. An increment that carries out of the significand renormalizes the result by one place and bumps the exponent. If that bump reaches the all-ones exponent, the result becomes an infinity with a zero significand. At the largest finite magnitude, round-to-nearest follows a dedicated rule: the guard bit alone selects between a signed infinity and the unchanged maximum. A subnormal value that rounds up into the leading-bit position is promoted to the smallest normal exponent. Operand unpacking, normalization, trapping and narrowing to single precision are handled elsewhere. The exponent input is never all ones.

Top module: `fp_round_unit`

## Requirements
- R1: With mode 2'b00 (nearest), a guard bit of 0 returns the truncated significand and exponent unchanged, whatever the round and sticky bits are.
- R2: With mode 2'b00, a guard bit of 1 together with a round or sticky bit of 1 returns the significand increased by one unit in the last place.
- R3: With mode 2'b00, guard=1, round=0 and sticky=0 is a tie. The significand is increased only when its bit 0 is 1, so the result always ends in 0.
- R4: With mode 2'b00, when the input is the largest finite magnitude (exponent 11'h7FE, significand all ones): guard=1 gives exponent 11'h7FF with a zero significand and the input sign; guard=0 gives the input unchanged.
- R5: With mode 2'b01 (toward zero), the output is always the truncated input.
- R6: With mode 2'b10 (toward +infinity), a positive value with any nonzero guard, round or sticky bit is increased by one ulp. A negative value is truncated.
- R7: With mode 2'b11 (toward -infinity), a negative value with any nonzero guard, round or sticky bit is increased in magnitude by one ulp. A positive value is truncated.
- R8: inexact_o is 1 exactly when at least one of guard, round and sticky is 1, in every mode.
- R9: An increment of an all-ones significand returns significand 53'h10000000000000 (bit 52 only) and the exponent plus one.
- R10: When a carry out of the significand takes the exponent to 11'h7FF, the significand output is zero.
- R11: When a subnormal input (exponent 0) rounds up so that bit 52 of the significand becomes 1, the exponent output is 1.
- R12: sign_o always equals sign_i.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sign_i | input | 1 | Sign of the unrounded value (1 = negative) |
| exp_i | input | 11 | Biased exponent, never all ones |
| sig_i | input | 53 | Significand including the leading bit |
| guard_i | input | 1 | First bit below the last kept place |
| round_i | input | 1 | Second bit below the last kept place |
| sticky_i | input | 1 | OR of all bits further below |
| mode_i | input | 2 | 00 nearest-even, 01 toward zero, 10 toward +inf, 11 toward -inf |
| sign_o | output | 1 | Sign of the result |
| exp_o | output | 11 | Rounded biased exponent |
| sig_o | output | 53 | Rounded significand |
| inexact_o | output | 1 | Set when any discarded bit is nonzero |

## Verification
The significand carry-out and the exponent overflow to infinity can occur in the same evaluation. The same holds for the tie rule and the largest-magnitude rule. Directed vectors put an all-ones significand at exponent 11'h7FE under every mode and every guard, round and sticky pattern. Each of these vectors is compared with a bench model on exponent, significand, sign and inexact, so the model decides whether the result must be infinity, the unchanged maximum or a plain carry into a larger exponent. Tie vectors with both values of bit 0, and subnormal vectors that round into the leading bit, extend this to the renormalizing paths.

// File: rtl/fp_round_pkg.sv
package fp_round_pkg;

    typedef enum logic [1:0] {
        RM_NEAR = 2'b00,
        RM_ZERO = 2'b01,
        RM_UP   = 2'b10,
        RM_DOWN = 2'b11
    } rmode_e;

endpackage

// File: rtl/round_decide.sv
module round_decide
    import fp_round_pkg::*;
(
    input  rmode_e mode,
    input  logic   neg,
    input  logic   lsb,
    input  logic   g,
    input  logic   r,
    input  logic   s,
    output logic   bump,
    output logic   lost
);

    logic any_lost;

    always_comb begin
        any_lost = g | r | s;
        unique case (mode)
            RM_NEAR: bump = g & (r | s | lsb);
            RM_ZERO: bump = 1'b0;
            RM_UP:   bump = ~neg & any_lost;
            RM_DOWN: bump = neg & any_lost;
            default: bump = 1'b0;
        endcase
        lost = any_lost;
    end

endmodule

// File: rtl/sig_incr.sv
module sig_incr #(
    parameter int unsigned SIG_W = 53
) (
    input  logic [SIG_W-1:0] sig,
    input  logic             bump,
    output logic [SIG_W-1:0] sum,
    output logic             cout
);

    logic [SIG_W:0] wide;

    always_comb begin
        wide = {1'b0, sig} + {{SIG_W{1'b0}}, bump};
        sum  = wide[SIG_W-1:0];
        cout = wide[SIG_W];
    end

endmodule

// File: rtl/exp_adjust.sv
module exp_adjust #(
    parameter int unsigned EXP_W = 11,
    parameter int unsigned SIG_W = 53
) (
    input  logic [EXP_W-1:0] exp_in,
    input  logic [SIG_W-1:0] sum,
    input  logic             cout,
    output logic [EXP_W-1:0] exp_out,
    output logic [SIG_W-1:0] sig_out
);

    localparam logic [EXP_W-1:0] EXP_ALL1 = {EXP_W{1'b1}};
    localparam logic [EXP_W-1:0] EXP_ONE  = {{(EXP_W-1){1'b0}}, 1'b1};

    always_comb begin
        if (cout) begin
            sig_out = {1'b1, sum[SIG_W-1:1]};
            exp_out = exp_in + EXP_ONE;
        end else begin
            sig_out = sum;
            exp_out = exp_in;
            if (exp_in == '0 && sum[SIG_W-1])
                exp_out = EXP_ONE;
        end
        if (exp_out == EXP_ALL1)
            sig_out = '0;
    end

endmodule

// File: rtl/fp_round_unit.sv
module fp_round_unit
    import fp_round_pkg::*;
#(
    parameter int unsigned EXP_W = 11,
    parameter int unsigned SIG_W = 53
) (
    input  logic             sign_i,
    input  logic [EXP_W-1:0] exp_i,
    input  logic [SIG_W-1:0] sig_i,
    input  logic             guard_i,
    input  logic             round_i,
    input  logic             sticky_i,
    input  logic [1:0]       mode_i,
    output logic             sign_o,
    output logic [EXP_W-1:0] exp_o,
    output logic [SIG_W-1:0] sig_o,
    output logic             inexact_o
);

    localparam logic [EXP_W-1:0] EXP_ALL1 = {EXP_W{1'b1}};
    localparam logic [EXP_W-1:0] EXP_TOP  = EXP_ALL1 - {{(EXP_W-1){1'b0}}, 1'b1};
    localparam logic [EXP_W-1:0] EXP_ONE  = {{(EXP_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic             sign;
        logic [EXP_W-1:0] exp;
        logic [SIG_W-1:0] sig;
        logic             inexact;
    } res_t;

    rmode_e           mode_sel;
    logic             bump;
    logic             lost;
    logic [SIG_W-1:0] inc_sum;
    logic             inc_cout;
    logic [EXP_W-1:0] adj_exp;
    logic [SIG_W-1:0] adj_sig;
    logic             at_max;
    res_t             res_d;

    assign mode_sel = rmode_e'(mode_i);

    round_decide u_decide (
        .mode (mode_sel),
        .neg  (sign_i),
        .lsb  (sig_i[0]),
        .g    (guard_i),
        .r    (round_i),
        .s    (sticky_i),
        .bump (bump),
        .lost (lost)
    );

    sig_incr #(.SIG_W(SIG_W)) u_incr (
        .sig  (sig_i),
        .bump (bump),
        .sum  (inc_sum),
        .cout (inc_cout)
    );

    exp_adjust #(.EXP_W(EXP_W), .SIG_W(SIG_W)) u_adjust (
        .exp_in  (exp_i),
        .sum     (inc_sum),
        .cout    (inc_cout),
        .exp_out (adj_exp),
        .sig_out (adj_sig)
    );

    always_comb begin
        at_max        = (exp_i == EXP_TOP) && (&sig_i);
        res_d.sign    = sign_i;
        res_d.exp     = adj_exp;
        res_d.sig     = adj_sig;
        res_d.inexact = lost;
        // largest finite magnitude under nearest: guard alone decides
        if (mode_sel == RM_NEAR && at_max) begin
            if (guard_i) begin
                res_d.exp = EXP_ALL1;
                res_d.sig = '0;
            end else begin
                res_d.exp = exp_i;
                res_d.sig = sig_i;
            end
        end
    end

    assign sign_o    = res_d.sign;
    assign exp_o     = res_d.exp;
    assign sig_o     = res_d.sig;
    assign inexact_o = res_d.inexact;

    always_comb begin
        // R5
        no_bump_rtz_chk: assert (!(mode_sel == RM_ZERO && bump));
        // R3
        tie_even_chk: assert (!(mode_sel == RM_NEAR && guard_i && !round_i && !sticky_i && !sig_i[0] && bump));
        // R10
        inf_zero_sig_chk: assert (!(exp_o == EXP_ALL1 && sig_o != '0));
        // R9
        carry_exp_chk: assert (!(inc_cout && exp_o != exp_i + EXP_ONE));
        // R6
        up_neg_trunc_chk: assert (!(mode_sel == RM_UP && sign_i && bump));
        // R4
        max_near_inf_chk: assert (!(mode_sel == RM_NEAR && at_max && guard_i && exp_o != EXP_ALL1));
    end

endmodule

// File: tb/sim_fp_round_unit.sv
module sim_fp_round_unit;

    localparam int CLK_P = 10;
    localparam int EW = 11;
    localparam int SW = 53;

    logic clk = 1'b0;
    always #(CLK_P/2) clk = ~clk;

    logic          sign_i, guard_i, round_i, sticky_i;
    logic [EW-1:0] exp_i;
    logic [SW-1:0] sig_i;
    logic [1:0]    mode_i;
    logic          sign_o, inexact_o;
    logic [EW-1:0] exp_o;
    logic [SW-1:0] sig_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    fp_round_unit u0 (
        .sign_i(sign_i), .exp_i(exp_i), .sig_i(sig_i),
        .guard_i(guard_i), .round_i(round_i), .sticky_i(sticky_i),
        .mode_i(mode_i), .sign_o(sign_o), .exp_o(exp_o),
        .sig_o(sig_o), .inexact_o(inexact_o)
    );

    // reference: returns {sign, exp, sig, inexact}
    function automatic logic [1+EW+SW:0] model(
        input logic s, input logic [EW-1:0] e, input logic [SW-1:0] m,
        input logic g, input logic r, input logic k, input logic [1:0] md);
        logic up;
        logic any;
        logic [SW:0] w;
        logic [EW-1:0] eo;
        logic [SW-1:0] mo;
        any = g | r | k;
        case (md)
            2'b00: up = g && (r || k || m[0]);
            2'b01: up = 1'b0;
            2'b10: up = !s && any;
            default: up = s && any;
        endcase
        w  = {1'b0, m} + (up ? 54'd1 : 54'd0);
        eo = e;
        mo = w[SW-1:0];
        if (w[SW]) begin
            mo = {1'b1, {(SW-1){1'b0}}};
            eo = e + 11'd1;
        end else if (e == 0 && mo[SW-1]) begin
            eo = 11'd1;
        end
        if (eo == 11'h7FF) mo = '0;
        return {s, eo, mo, any};
    endfunction

    task automatic apply_and_check(
        input logic s, input logic [EW-1:0] e, input logic [SW-1:0] m,
        input logic g, input logic r, input logic k, input logic [1:0] md,
        input string tag);
        logic [1+EW+SW:0] exp_v;
        logic [1+EW+SW:0] act_v;
        @(negedge clk);
        sign_i = s; exp_i = e; sig_i = m;
        guard_i = g; round_i = r; sticky_i = k; mode_i = md;
        #1;
        exp_v = model(s, e, m, g, r, k, md);
        act_v = {sign_o, exp_o, sig_o, inexact_o};
        checks++;
        if (act_v !== exp_v) begin
            errors++;
            $display("FAIL %s mode=%b grs=%b%b%b actual s=%b e=%h m=%h x=%b expected s=%b e=%h m=%h x=%b",
                tag, md, g, r, k, act_v[1+EW+SW], act_v[EW+SW:SW+1], act_v[SW:1], act_v[0],
                exp_v[1+EW+SW], exp_v[EW+SW:SW+1], exp_v[SW:1], exp_v[0]);
        end
    endtask

    localparam logic [SW-1:0] ONES = {SW{1'b1}};
    localparam logic [SW-1:0] LEAD = {1'b1, {(SW-1){1'b0}}};

    initial begin
        logic [SW-1:0] rm;
        logic [EW-1:0] re;
        logic [5:0]    pick;
        sign_i = 0; exp_i = 0; sig_i = 0; guard_i = 0; round_i = 0; sticky_i = 0; mode_i = 0;
        void'($urandom(32'd2024));
        // zero input state: exact zero stays zero (R8, R1)
        apply_and_check(0, 0, 0, 0, 0, 0, 2'b00, "R8 idle");
        // R1: guard 0 truncates
        apply_and_check(0, 11'h400, LEAD | 53'h5, 0, 1, 1, 2'b00, "R1");
        // R2: guard with sticky increments
        apply_and_check(1, 11'h3FF, LEAD | 53'h4, 1, 0, 1, 2'b00, "R2");
        apply_and_check(0, 11'h3FF, LEAD | 53'h2, 1, 1, 0, 2'b00, "R2");
        // R3: ties, odd and even
        apply_and_check(0, 11'h3FF, LEAD | 53'h3, 1, 0, 0, 2'b00, "R3 odd");
        apply_and_check(1, 11'h3FF, LEAD | 53'h6, 1, 0, 0, 2'b00, "R3 even");
        // R4: maximum magnitude under nearest
        apply_and_check(1, 11'h7FE, ONES, 1, 0, 0, 2'b00, "R4 inf");
        apply_and_check(0, 11'h7FE, ONES, 0, 1, 1, 2'b00, "R4 keep");
        // R5
        apply_and_check(0, 11'h7FE, ONES, 1, 1, 1, 2'b01, "R5");
        apply_and_check(1, 11'h123, LEAD | 53'h9, 1, 0, 0, 2'b01, "R5");
        // R6
        apply_and_check(0, 11'h200, LEAD, 0, 0, 1, 2'b10, "R6 pos");
        apply_and_check(1, 11'h200, LEAD, 1, 1, 1, 2'b10, "R6 neg");
        // R7
        apply_and_check(1, 11'h200, LEAD | 53'h1, 0, 1, 0, 2'b11, "R7 neg");
        apply_and_check(0, 11'h200, LEAD | 53'h1, 1, 0, 0, 2'b11, "R7 pos");
        // R9: carry renormalizes
        apply_and_check(0, 11'h3FF, ONES, 1, 1, 0, 2'b00, "R9");
        apply_and_check(1, 11'h010, ONES, 0, 0, 1, 2'b11, "R9");
        // R10: overflow to infinity in directed modes
        apply_and_check(0, 11'h7FE, ONES, 0, 0, 1, 2'b10, "R10");
        apply_and_check(1, 11'h7FE, ONES, 0, 1, 0, 2'b11, "R10");
        // R11: subnormal promoted
        apply_and_check(0, 11'h000, {1'b0, {(SW-1){1'b1}}}, 1, 0, 0, 2'b00, "R11");
        apply_and_check(1, 11'h000, 53'h1, 1, 0, 0, 2'b11, "R11 small");
        // exhaustive guard/round/sticky/mode at max magnitude (R4, R10, R12)
        for (int md = 0; md < 4; md++)
            for (int grs = 0; grs < 8; grs++)
                for (int sg = 0; sg < 2; sg++)
                    apply_and_check(sg[0], 11'h7FE, ONES, grs[2], grs[1], grs[0], md[1:0], "R12 max sweep");
        // constrained random
        for (int i = 0; i < 4000; i++) begin
            pick = 6'($urandom_range(0, 63));
            re = (pick < 4) ? 11'h7FE : (pick < 8) ? 11'h000 : 11'($urandom_range(0, 2046));
            rm = {$urandom, $urandom} [SW-1:0];
            if (pick[0] && pick < 16) rm = ONES;
            rm[SW-1] = (re != 0);
            mode_i = 2'($urandom_range(0, 3));
            apply_and_check(1'($urandom), re, rm, 1'($urandom), 1'($urandom), 1'($urandom),
                2'($urandom_range(0, 3)), "R2 R6 R7 R8 random");
        end
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog R1 actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule